// File: doc/BRIEF.md
# Snapshot Arbiter with Switchable Grant Order

This block shares one resource among a parameterised number of requesters. Whenever no batch is in progress and at least one request line is high, the arbiter copies the request vector into an internal batch register. It then serves the members of that batch one at a time, each time the resource reports that it is ready. A requester that raises its line while a batch is in progress waits for the following batch. The next batch is captured only after every member of the current one has been served.

Each grant is one-hot. It stays asserted until the resource pulses `done_i`. Within a batch the serving order comes from a count input. A count of zero selects a rotating order. A non-zero count selects fixed priority, with requester 0 highest. In that mode a requester that still holds its line at `done_i` may be served again straight away, up to the count in consecutive grants, before a lower-priority batch member is served.

Top module: `snap_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the grant vector, the batch register and the consecutive-grant streak are cleared, and the rotating pointer is set to requester 0. The first grant after reset in rotating mode therefore goes to the lowest-numbered batch member.
- R2: When no grant is active, the batch is empty and `req_i` is non-zero, the batch register takes the value of `req_i` at that clock edge. Bits raised in `req_i` while the batch is non-empty are not added to it.
- R3: At most one bit of `grant_o` is high at any time. A grant holds unchanged until the cycle in which `done_i` is high.
- R4: A new grant is issued only at a clock edge where no grant is active, the batch is non-empty and `res_ready_i` is high. While `res_ready_i` is low, `grant_o` stays zero.
- R5: With `weight_i` = 0 (rotating order), the search starts at the rotating pointer and wraps from N-1 to 0. After each completed grant, the pointer moves to the requester after the one just served.
- R6: With `weight_i` > 0 (priority order), the lowest-numbered member of the batch is granted first.
- R7: In priority order, when `done_i` completes a grant whose requester still holds `req_i` high, that requester stays in the batch as long as its number of consecutive completed grants is below `weight_i`. Otherwise its batch bit is cleared and the streak restarts. In rotating order the bit is always cleared at `done_i`.
- R8: A requester that drops its request after capture is still served once in that batch. `done_i` with no grant active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_REQ | Request line per requester |
| res_ready_i | input | 1 | Resource can accept a new owner |
| done_i | input | 1 | Resource finished with the current owner (pulse) |
| weight_i | input | CNT_W | 0 selects rotating order, otherwise the consecutive-grant limit in priority order |
| grant_o | output | N_REQ | One-hot grant |

## Verification
The bench uses the defaults N_REQ = 4 and CNT_W = 3. Four requesters are enough to place a late arrival at a higher priority than the batch already being served. They also let the rotating pointer start mid-vector, so the wrap from requester 3 back to 0 is exercised. A three-bit count allows a limit of 2, so a held request can be re-granted once and then must yield to the next member.

// File: rtl/snap_arb_pkg.sv
// Package: shared types for the snapshot arbiter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package snap_arb_pkg;

    // Grant-order policy inside one batch
    typedef enum logic {
        ORDER_ROTATE   = 1'b0,
        ORDER_PRIORITY = 1'b1
    } order_e;

endpackage

// File: rtl/snap_rr_pick.sv
// Module: snap_rr_pick
// Finds the first set bit of `pend` when searching upward from `start`,
// wrapping past N-1 to 0. Purely combinational.
// Assumes: start < N.
module snap_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Rotating search over all offsets; first hit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(start) + k;
            if (c >= N) c = c - N;
            if (!found && pend[c]) begin
                found = 1'b1;
                idx   = IW'(c);
            end
        end
    end

endmodule

// File: rtl/snap_prio_pick.sv
// Module: snap_prio_pick
// Fixed-priority selector: the lowest set index of `pend` wins.
// Assumes: nothing; purely combinational.
module snap_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Downward scan so that the lowest index is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end

endmodule

// File: rtl/snap_streak.sv
// Module: snap_streak
// Counts consecutive completed grants to the same requester and reports
// whether the next completion reaches the programmed limit.
// Assumes: `step` pulses once per completed grant; `stay` says whether that
// requester keeps its batch bit.
module snap_streak #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          stay,
    input  logic [CW-1:0] limit,
    output logic          exhausted
);

    logic [CW-1:0] streak_q;

    // Limit reached once this completion is counted
    assign exhausted = ({1'b0, streak_q} + (CW+1)'(1)) >= {1'b0, limit};

    // Advance on a kept requester, restart otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      streak_q <= '0;
        else if (step)   streak_q <= stay ? streak_q + CW'(1) : '0;
    end

endmodule

// File: rtl/snap_arbiter.sv
// Module: snap_arbiter (top)
// Batch-based arbiter for one shared resource. Captures the pending
// request vector when idle, serves its members one at a time when the
// resource is ready, and recaptures only after the batch drains.
// Assumes: done_i is only meaningful while a grant is active; N_REQ >= 2.
module snap_arbiter
    import snap_arb_pkg::*;
#(
    parameter int N_REQ = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             res_ready_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] weight_i,
    output logic [N_REQ-1:0] grant_o
);

    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(N_REQ - 1);

    logic [N_REQ-1:0] batch_q;
    logic [N_REQ-1:0] grant_q;
    logic [IW-1:0]    ptr_q;
    logic [IW-1:0]    owner_q;

    order_e        order;
    logic          rr_found, pr_found, pick_found;
    logic [IW-1:0] rr_idx, pr_idx, pick_idx;
    logic          busy, finish, keep, exhausted;

    // Policy follows the count: zero means rotating order
    assign order = (weight_i == '0) ? ORDER_ROTATE : ORDER_PRIORITY;
    assign busy   = |grant_q;
    assign finish = busy && done_i;

    snap_rr_pick #(.N(N_REQ), .IW(IW)) u_rr (
        .pend  (batch_q),
        .start (ptr_q),
        .found (rr_found),
        .idx   (rr_idx)
    );

    snap_prio_pick #(.N(N_REQ), .IW(IW)) u_pr (
        .pend  (batch_q),
        .found (pr_found),
        .idx   (pr_idx)
    );

    // Select the winner of the active policy
    always_comb begin
        if (order == ORDER_ROTATE) begin
            pick_found = rr_found;
            pick_idx   = rr_idx;
        end else begin
            pick_found = pr_found;
            pick_idx   = pr_idx;
        end
    end

    // Requester keeps its batch bit only in priority order, below the limit
    assign keep = (order == ORDER_PRIORITY) && req_i[owner_q] && !exhausted;

    snap_streak #(.CW(CNT_W)) u_streak (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (finish),
        .stay      (keep),
        .limit     (weight_i),
        .exhausted (exhausted)
    );

    // Batch capture, grant issue and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batch_q <= '0;
            grant_q <= '0;
            owner_q <= '0;
        end else if (finish) begin
            grant_q <= '0;
            if (!keep) batch_q[owner_q] <= 1'b0;
        end else if (!busy) begin
            if (batch_q == '0) begin
                if (req_i != '0) batch_q <= req_i;
            end else if (res_ready_i && pick_found) begin
                grant_q          <= '0;
                grant_q[pick_idx] <= 1'b1;
                owner_q          <= pick_idx;
            end
        end
    end

    // Rotating pointer moves past each completed owner
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (finish) ptr_q <= (owner_q == LAST_IDX) ? '0 : owner_q + IW'(1);
    end

    assign grant_o = grant_q;

    // ---------------- assertions ----------------
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (grant_o == '0 && batch_q == '0 && ptr_q == '0));

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && batch_q == '0 && req_i != '0) |=> batch_q == $past(req_i));

    p_no_late_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (batch_q != '0) |=> (batch_q & ~$past(batch_q)) == '0);

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_grant_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !done_i) |=> $stable(grant_o));

    p_grant_in_batch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~batch_q) == '0);

    p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0 && !res_ready_i) |=> grant_o == '0);

    p_rotate_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && weight_i == '0) |=> (batch_q & $past(grant_o)) == '0);

endmodule

// File: tb/snap_arbiter_bench.sv
module snap_arbiter_bench;

    localparam int N = 4;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic          ready;
    logic          done;
    logic [CW-1:0] weight;
    logic [N-1:0]  grant;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    snap_arbiter #(.N_REQ(N), .CNT_W(CW)) u_snap_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .res_ready_i(ready),
        .done_i(done), .weight_i(weight), .grant_o(grant)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; ready = 1'b1; done = 1'b0; weight = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Wait for a grant; returns index or -1 on timeout
    task automatic wait_grant(output int idx);
        idx = -1;
        for (int t = 0; t < 30; t++) begin
            if (grant != '0) begin
                for (int b = 0; b < N; b++) if (grant[b]) idx = b;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_grant();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic serve(input string tag, input int exp);
        int got;
        wait_grant(got);
        check(tag, got, exp);
        finish_grant();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 grant after reset", int'(grant), 0);
        req = 4'b1010;
        serve("R1 first rotate grant lowest", 1);
        serve("R1 second rotate grant", 3);
    endtask

    task automatic t_drop_after_capture();
        int got;
        do_reset();
        req = 4'b1011;
        wait_grant(got);
        check("R8 first of batch", got, 0);
        req = '0;
        finish_grant();
        serve("R8 dropped requester still served", 1);
        serve("R8 dropped requester still served", 3);
        repeat (4) @(negedge clk);
        check("R8 batch drained, no grant", int'(grant), 0);
        finish_grant();
        repeat (2) @(negedge clk);
        check("R8 stray done no grant", int'(grant), 0);
    endtask

    task automatic t_late_arrival();
        int got;
        do_reset();
        weight = 3'd1;
        req = 4'b0110;
        wait_grant(got);
        check("R6 lowest member first", got, 1);
        req = 4'b0001;
        finish_grant();
        serve("R2 late requester waits", 2);
        serve("R2 late requester next batch", 0);
    endtask

    task automatic t_weighted();
        int got;
        do_reset();
        weight = 3'd2;
        req = 4'b0011;
        wait_grant(got);
        check("R7 first grant", got, 0);
        repeat (3) @(negedge clk);
        check("R3 grant holds without done", int'(grant), 1);
        finish_grant();
        serve("R7 repeat grant within limit", 0);
        serve("R7 next member after limit", 1);
        serve("R7 repeat for member 1", 1);
        serve("R7 new batch after drain", 0);
    endtask

    task automatic t_rotate_wrap();
        do_reset();
        req = 4'b0100;
        serve("R5 move pointer", 2);
        req = 4'b1011;
        serve("R5 start after last", 3);
        serve("R5 wrap to 0", 0);
        serve("R5 continue", 1);
    endtask

    task automatic t_ready();
        do_reset();
        ready = 1'b0;
        req = 4'b0001;
        repeat (6) @(negedge clk);
        check("R4 no grant while busy resource", int'(grant), 0);
        ready = 1'b1;
        serve("R4 grant once ready", 0);
    endtask

    initial begin
        t_reset();
        t_drop_after_capture();
        t_late_arrival();
        t_weighted();
        t_rotate_wrap();
        t_ready();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule